// File: doc/BRIEF.md
# MII Receive Frame Assembler

This block sits between an external PHY that delivers 4-bit nibbles with a receive-data-valid flag and a host-side bus interface that consumes whole bytes. It finds the start of each frame by locking onto a run of preamble nibbles and the start-of-frame delimiter. It then pairs nibbles into bytes and passes those bytes on with a valid strobe. The first delivered byte of a frame is marked, and so is the last delivered byte.

The four frame check sequence bytes at the tail of every frame are held back. They are never delivered, but they are still folded into a CRC-32 check, and a CRC error flag is updated when the frame ends. The destination address is also examined as it passes. The block raises a broadcast or multicast flag, and it publishes a 6-bit hash taken from the running CRC for the address filter that follows. In delayed-CRC mode, the CRC ignores the first four bytes of the frame, which suits frames that carry a prefix ahead of the real data.

Top module: `mii_rx_assembler`

## Requirements
- R1: A frame starts only after one or more nibbles of value 0x5 followed directly by a nibble 0xD while `rxdv` is high. If any other nibble appears before the 0xD, nothing from that burst is delivered until `rxdv` has gone low.
- R2: After the 0xD nibble, nibbles are paired into bytes with the first nibble as bits [3:0] and the second as bits [7:4]. Delivered bytes appear in arrival order on `out_data` with `out_valid`.
- R3: The final four bytes of a frame are never delivered. A frame of N bytes delivers N-4 bytes, and a frame of four or fewer bytes delivers none.
- R4: `out_sof` is high together with `out_valid` on the first delivered byte of a frame and on no other byte.
- R5: `out_eof` is high together with `out_valid` on the last delivered byte, which is the byte just before the four withheld bytes, and on no other byte.
- R6: The CRC uses a reflected register preset to 0xFFFFFFFF with polynomial 0xEDB88320, and each byte is taken least significant bit first. At frame end `crc_err` becomes 1 if the register does not equal 0xDEBB20E3 and 0 if it does. The flag holds its value until the next frame end.
- R7: When `dly_crc_en` is high, bytes 0 to 3 of the frame are left out of the CRC, and accumulation starts with byte 4.
- R8: After the sixth byte of a frame, `bcast` is 1 exactly when all six destination bytes are 0xFF.
- R9: After the sixth byte, `mcast` is 1 exactly when bit 0 of byte 0 is 1 and the frame is not broadcast.
- R10: After the sixth byte, `hash` holds bits [31:26] of the CRC register once that byte has been included, and `hash_valid` is 1. The start of the next frame clears `bcast`, `mcast` and `hash_valid`, and a frame shorter than six bytes leaves them at 0.
- R11: After reset, `out_valid`, `out_sof`, `out_eof`, `crc_err`, `bcast`, `mcast` and `hash_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock, one nibble per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| rxd | input | 4 | Nibble from the PHY |
| rxdv | input | 1 | Nibble valid from the PHY |
| dly_crc_en | input | 1 | Skip the first four bytes in the CRC |
| out_data | output | 8 | Delivered byte |
| out_valid | output | 1 | `out_data` holds a byte this cycle |
| out_sof | output | 1 | First delivered byte of the frame |
| out_eof | output | 1 | Last delivered byte of the frame |
| crc_err | output | 1 | CRC check result of the most recent frame |
| bcast | output | 1 | Destination is all ones |
| mcast | output | 1 | Destination is a group address, not broadcast |
| hash | output | 6 | CRC-derived address hash |
| hash_valid | output | 1 | `hash`, `bcast` and `mcast` are valid for this frame |

## Verification
If the nibble phase slips, every delivered byte comes out with its halves swapped or mixed with the next byte, and this shows on the very first data byte after the delimiter. A wrong fill count in the withholding pipeline either lets FCS bytes leak out or swallows data bytes, and the delivered length then differs from N-4 by the end of the frame. A CRC register that starts, stops or skips at the wrong byte shows two ways. It changes `hash` on the sixth byte, and it flips `crc_err` on good frames or bad frames two cycles after `rxdv` falls.

// File: rtl/mii_rx_pkg.sv
`timescale 1ns/1ps
package mii_rx_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_PRE, ST_DATA, ST_DROP} rx_state_e;

  localparam logic [3:0]  NIB_PRE     = 4'h5;
  localparam logic [3:0]  NIB_SFD     = 4'hD;
  localparam logic [31:0] CRC_POLY    = 32'hEDB88320;
  localparam logic [31:0] CRC_INIT    = 32'hFFFFFFFF;
  localparam logic [31:0] CRC_RESIDUE = 32'hDEBB20E3;

  // one byte through the reflected CRC-32 register, LSB first
  function automatic logic [31:0] crc32_byte(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'h0, b};
    for (int i = 0; i < 8; i++)
      r = r[0] ? ((r >> 1) ^ CRC_POLY) : (r >> 1);
    return r;
  endfunction
endpackage

// File: rtl/rx_nibble_fsm.sv
`timescale 1ns/1ps
module rx_nibble_fsm
  import mii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] rxd,
  input  logic       rxdv,
  output logic [7:0] byte_q,
  output logic       byte_stb,
  output logic       start_evt,
  output logic       end_evt
);
  rx_state_e  state;
  logic       phase;
  logic [3:0] lo_nib;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      phase     <= 1'b0;
      lo_nib    <= 4'h0;
      byte_q    <= 8'h00;
      byte_stb  <= 1'b0;
      start_evt <= 1'b0;
      end_evt   <= 1'b0;
    end else begin
      byte_stb  <= 1'b0;
      start_evt <= 1'b0;
      end_evt   <= 1'b0;
      case (state)
        ST_IDLE: if (rxdv) state <= (rxd == NIB_PRE) ? ST_PRE : ST_DROP;
        ST_PRE: begin
          if (!rxdv) state <= ST_IDLE;
          else if (rxd == NIB_SFD) begin
            state     <= ST_DATA;
            phase     <= 1'b0;
            start_evt <= 1'b1;
          end else if (rxd != NIB_PRE) state <= ST_DROP;
        end
        ST_DATA: begin
          if (!rxdv) begin
            state   <= ST_IDLE;
            end_evt <= 1'b1;
          end else if (!phase) begin
            lo_nib <= rxd;
            phase  <= 1'b1;
          end else begin
            byte_q   <= {rxd, lo_nib};
            byte_stb <= 1'b1;
            phase    <= 1'b0;
          end
        end
        default: if (!rxdv) state <= ST_IDLE;
      endcase
    end
  end

  // R2: two nibbles per byte, so strobes never come back to back
  a_r2_pair_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    byte_stb |=> !byte_stb);
  // R1: a frame start is never on the same cycle as a byte
  a_r1_start_alone: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> !byte_stb && !end_evt);
endmodule

// File: rtl/rx_crc32.sv
`timescale 1ns/1ps
module rx_crc32
  import mii_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        en,
  input  logic [7:0]  data,
  output logic [31:0] crc_q,
  output logic [31:0] crc_next
);
  assign crc_next = crc32_byte(crc_q, data);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC_INIT;
    else if (en)         crc_q <= crc_next;
  end

  // R7: register holds when not enabled
  a_r7_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !clear |=> $stable(crc_q));
endmodule

// File: rtl/rx_fcs_delay.sv
`timescale 1ns/1ps
module rx_fcs_delay #(
  parameter int FCS_BYTES = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear,
  input  logic       push,
  input  logic [7:0] push_data,
  input  logic       flush,
  output logic [7:0] out_data,
  output logic       out_valid,
  output logic       out_sof,
  output logic       out_eof
);
  localparam int HOLD = FCS_BYTES + 1;
  localparam int CW   = $clog2(HOLD + 1);
  localparam logic [CW-1:0] HOLD_C = CW'(HOLD);

  logic [7:0]    mem [HOLD];
  logic [CW-1:0] count;
  logic          emitted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count     <= '0;
      emitted   <= 1'b0;
      out_data  <= 8'h00;
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      for (int i = 0; i < HOLD; i++) mem[i] <= 8'h00;
    end else begin
      out_valid <= 1'b0;
      out_sof   <= 1'b0;
      out_eof   <= 1'b0;
      if (clear) begin
        count   <= '0;
        emitted <= 1'b0;
      end else if (push) begin
        if (count < HOLD_C) begin
          mem[count] <= push_data;
          count      <= count + 1'b1;
        end else begin
          out_data  <= mem[0];
          out_valid <= 1'b1;
          out_sof   <= !emitted;
          emitted   <= 1'b1;
          for (int i = 0; i < HOLD - 1; i++) mem[i] <= mem[i+1];
          mem[HOLD-1] <= push_data;
        end
      end else if (flush) begin
        if (count == HOLD_C) begin
          out_data  <= mem[0];
          out_valid <= 1'b1;
          out_sof   <= !emitted;
          out_eof   <= 1'b1;
        end
        count   <= '0;
        emitted <= 1'b0;
      end
    end
  end

  // R3: fill level never exceeds the withheld bytes plus one
  a_r3_fill_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= HOLD_C);
  // R4: start marker only on a delivered byte
  a_r4_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> out_valid);
  // R5: end marker only on a delivered byte, and only after a flush
  a_r5_eof_valid: assert property (@(posedge clk) disable iff (!rst_n)
    out_eof |-> out_valid && $past(flush));
endmodule

// File: rtl/mii_rx_assembler.sv
`timescale 1ns/1ps
module mii_rx_assembler
  import mii_rx_pkg::*;
#(
  parameter int FCS_BYTES  = 4,
  parameter int ADDR_BYTES = 6,
  parameter int DLY_BYTES  = 4,
  parameter int HASH_W     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        rxd,
  input  logic              rxdv,
  input  logic              dly_crc_en,
  output logic [7:0]        out_data,
  output logic              out_valid,
  output logic              out_sof,
  output logic              out_eof,
  output logic              crc_err,
  output logic              bcast,
  output logic              mcast,
  output logic [HASH_W-1:0] hash,
  output logic              hash_valid
);
  localparam int IW = $clog2(ADDR_BYTES + 1);
  localparam logic [IW-1:0] IDX_SAT  = IW'(ADDR_BYTES);
  localparam logic [IW-1:0] IDX_LAST = IW'(ADDR_BYTES - 1);
  localparam logic [IW-1:0] IDX_DLY  = IW'(DLY_BYTES);

  logic [7:0]    byte_q;
  logic          byte_stb, start_evt, end_evt;
  logic [31:0]   crc_q, crc_next;
  logic          crc_en;
  logic [IW-1:0] idx;
  logic          bc_run, mc_bit, bc_now;

  rx_nibble_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rxdv(rxdv),
    .byte_q(byte_q), .byte_stb(byte_stb),
    .start_evt(start_evt), .end_evt(end_evt)
  );

  assign crc_en = byte_stb && (!dly_crc_en || idx >= IDX_DLY);

  rx_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clear(start_evt), .en(crc_en),
    .data(byte_q), .crc_q(crc_q), .crc_next(crc_next)
  );

  rx_fcs_delay #(.FCS_BYTES(FCS_BYTES)) u_dly (
    .clk(clk), .rst_n(rst_n), .clear(start_evt),
    .push(byte_stb), .push_data(byte_q), .flush(end_evt),
    .out_data(out_data), .out_valid(out_valid),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  assign bc_now = (idx == '0 ? 1'b1 : bc_run) && (byte_q == 8'hFF);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx        <= '0;
      bc_run     <= 1'b0;
      mc_bit     <= 1'b0;
      bcast      <= 1'b0;
      mcast      <= 1'b0;
      hash       <= '0;
      hash_valid <= 1'b0;
      crc_err    <= 1'b0;
    end else begin
      if (start_evt) begin
        idx        <= '0;
        bcast      <= 1'b0;
        mcast      <= 1'b0;
        hash_valid <= 1'b0;
      end else if (byte_stb) begin
        if (idx != IDX_SAT) idx <= idx + 1'b1;
        if (idx == '0) mc_bit <= byte_q[0];
        if (idx < IDX_LAST) bc_run <= bc_now;
        if (idx == IDX_LAST) begin
          bcast      <= bc_now;
          mcast      <= mc_bit && !bc_now;
          hash       <= crc_next[31 -: HASH_W];
          hash_valid <= 1'b1;
        end
      end
      if (end_evt) crc_err <= (crc_q != CRC_RESIDUE);
    end
  end

  // R6: the error flag only moves at a frame end
  a_r6_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !end_evt |=> $stable(crc_err));
  // R8 / R9: a frame is never both broadcast and multicast
  a_r9_flag_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(bcast && mcast));
  // R10: a published hash does not change while it is valid
  a_r10_hash_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hash_valid |=> $stable(hash));
  // R10: flags drop on the cycle after a frame start
  a_r10_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !hash_valid && !bcast && !mcast);
endmodule

// File: tb/mii_rx_assembler_test.sv
`timescale 1ns/1ps
module mii_rx_assembler_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rxd;
  logic       rxdv;
  logic       dly_crc_en;
  logic [7:0] out_data;
  logic       out_valid, out_sof, out_eof, crc_err, bcast, mcast, hash_valid;
  logic [5:0] hash;

  always #5 clk = ~clk;

  mii_rx_assembler uut (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .rxdv(rxdv), .dly_crc_en(dly_crc_en),
    .out_data(out_data), .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
    .crc_err(crc_err), .bcast(bcast), .mcast(mcast), .hash(hash), .hash_valid(hash_valid)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;

  logic [7:0] fr [0:127];
  int         flen;
  logic [7:0] got [0:127];
  logic       gsof [0:127];
  logic       geof [0:127];
  int         gn;

  always @(negedge clk)
    if (out_valid && gn < 128) begin
      got[gn]  = out_data;
      gsof[gn] = out_sof;
      geof[gn] = out_eof;
      gn++;
    end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // bit-serial restatement of the reflected CRC-32 step
  function automatic logic [31:0] tb_crc(input logic [31:0] c, input logic [7:0] b);
    logic fb;
    for (int i = 0; i < 8; i++) begin
      fb = c[0] ^ b[i];
      c  = {1'b0, c[31:1]} ^ (fb ? 32'hEDB88320 : 32'h0);
    end
    return c;
  endfunction

  task automatic nib(input logic [3:0] d, input logic v);
    @(negedge clk);
    rxd  = d;
    rxdv = v;
  endtask

  task automatic build(input int kind, input int n, input bit dly, input bit corrupt);
    logic [31:0] c;
    for (int i = 0; i < n; i++) begin
      if (i < 6)
        case (kind)
          1:       fr[i] = 8'hFF;
          2:       fr[i] = (i == 0) ? 8'h01 : 8'h5E + 8'(i);
          default: fr[i] = (i == 0) ? 8'h02 : 8'h10 * 8'(i) + 8'h3;
        endcase
      else fr[i] = 8'((i * 37 + kind * 11) & 255);
    end
    c = 32'hFFFFFFFF;
    for (int i = 0; i < n; i++) if (!dly || i >= 4) c = tb_crc(c, fr[i]);
    c = ~c;
    for (int k = 0; k < 4; k++) fr[n+k] = c[8*k +: 8];
    flen = n + 4;
    if (corrupt) fr[n/2] = fr[n/2] ^ 8'h10;
  endtask

  task automatic run_frame(input bit dly, input bit good_pre, input string tag);
    logic [31:0] c, h;
    int   exp_n;
    bit   exp_bc, exp_mc, exp_hv;
    logic old_err, old_hv;
    dly_crc_en = dly;
    old_err = crc_err;
    old_hv  = hash_valid;
    gn = 0;
    if (!good_pre) begin
      nib(4'h5, 1); nib(4'h5, 1); nib(4'h3, 1);
    end
    for (int i = 0; i < 7; i++) nib(4'h5, 1);
    nib(4'hD, 1);
    for (int i = 0; i < flen; i++) begin
      nib(fr[i][3:0], 1);
      nib(fr[i][7:4], 1);
    end
    for (int i = 0; i < 8; i++) nib(4'h0, 0);

    if (!good_pre) begin
      check("R1", {tag, " bytes after bad preamble"}, gn, 0);
      check("R1", {tag, " crc_err untouched"}, crc_err, old_err);
      check("R1", {tag, " hash_valid untouched"}, hash_valid, old_hv);
      return;
    end
    exp_n = (flen >= 5) ? flen - 4 : 0;
    check("R3", {tag, " delivered count"}, gn, exp_n);
    for (int i = 0; i < gn && i < exp_n; i++) begin
      check("R2", {tag, " byte"}, got[i], fr[i]);
      check("R4", {tag, " sof"}, gsof[i], i == 0);
      check("R5", {tag, " eof"}, geof[i], i == exp_n - 1);
    end
    c = 32'hFFFFFFFF;
    for (int i = 0; i < flen; i++) if (!dly || i >= 4) c = tb_crc(c, fr[i]);
    check(dly ? "R7" : "R6", {tag, " crc_err"}, crc_err, c != 32'hDEBB20E3);
    exp_hv = flen >= 6;
    exp_bc = exp_hv;
    for (int i = 0; i < 6; i++) if (i >= flen || fr[i] != 8'hFF) exp_bc = 0;
    exp_mc = exp_hv && fr[0][0] && !exp_bc;
    check("R8", {tag, " bcast"}, bcast, exp_bc);
    check("R9", {tag, " mcast"}, mcast, exp_mc);
    check("R10", {tag, " hash_valid"}, hash_valid, exp_hv);
    if (exp_hv) begin
      h = 32'hFFFFFFFF;
      for (int i = 0; i < 6; i++) if (!dly || i >= 4) h = tb_crc(h, fr[i]);
      check("R10", {tag, " hash"}, hash, h[31:26]);
    end
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    int sizes [5] = '{1, 5, 6, 13, 50};
    rst_n = 0; rxd = 0; rxdv = 0; dly_crc_en = 0; gn = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11", "out_valid after reset", out_valid, 0);
    check("R11", "crc_err after reset", crc_err, 0);
    check("R11", "flags after reset", {bcast, mcast, hash_valid, out_sof, out_eof}, 0);

    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++)
        for (int s = 0; s < 5; s++)
          for (int e = 0; e < 2; e++) begin
            build(k, sizes[s], d[0], e[0]);
            run_frame(d[0], 1, "sweep");
          end

    // good FCS computed over the whole frame, but checked in delayed mode
    build(0, 20, 0, 0);
    run_frame(1, 1, "mode mismatch R7");
    // too short to carry data: nothing delivered, R3
    build(1, 20, 0, 0);
    run_frame(0, 1, "prep");
    flen = 3; fr[0] = 8'h11; fr[1] = 8'h22; fr[2] = 8'h33;
    run_frame(0, 1, "short R3");
    // corrupted preamble after a valid frame, R1
    build(2, 12, 0, 0);
    run_frame(0, 1, "prep2");
    build(0, 12, 0, 0);
    run_frame(0, 0, "bad preamble");

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule